// File: doc/BRIEF.md
# I/O Space Wait-State Generator

This block paces accesses to a 2048-word external I/O space. A requester presents a request together with an address, a read/write flag, the four per-region wait-count fields and a global timing-mode bit. The block then drives the I/O select strobe for the whole access. It holds the ready signal low for a computed number of wait cycles and raises it for exactly one cycle to end the access.

Only the low eleven address bits take part in decoding. Bits [10:9] pick one of four 512-word regions, and each region owns a 3-bit wait field. The mode bit chooses how that field becomes a wait length. In direct mode the length is N. In stretched mode it is 2N+1, which reaches at most 15. The block captures the chosen wait length and the direction when it accepts a request, so the access runs to completion on those captured values. Decoding of register writes from the core and the data path belong to other blocks.

Top module: `io_wait_gen`

## Requirements
- R1: After a synchronous active-high reset, `iosel_o`, `ready_o` and `io_wr_o` are all low.
- R2: Address bits [10:9] select the wait field. Value k selects `wait_cfg_i[3k+2:3k]`, so 0x000–0x1FF uses field 0 and 0x600–0x7FF uses field 3. Address bits above bit 10 have no effect on timing.
- R3: With `mode_i` = 0, an access inserts exactly W = N wait cycles, where N is the selected field. `ready_o` is high in the (W+1)-th cycle of the strobe.
- R4: With `mode_i` = 1, an access inserts W = 2N+1 wait cycles, so N = 7 gives 15.
- R5: Reads (`wr_i` = 0) and writes (`wr_i` = 1) get identical timing. `io_wr_o` equals the captured `wr_i` throughout the access.
- R6: The wait length and direction are captured at acceptance. Changes to `wait_cfg_i`, `mode_i`, `addr_i` or `wr_i` during an access do not alter it.
- R7: `iosel_o` rises in the cycle after a request is accepted and stays high through the ready cycle. It is low in the next cycle and whenever no access is in progress. `ready_o` is high for one cycle and only while `iosel_o` is high.
- R8: A request is accepted only in a cycle where `iosel_o` is low. A request held high while an access is in progress does not start another access.
- R9: When W = 0, `ready_o` is high in the first strobe cycle, so the access lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, sampled while idle |
| addr_i | input | BUS_AW (14) | External address bus; low 11 bits decoded |
| wr_i | input | 1 | 1 = write, 0 = read |
| wait_cfg_i | input | NREGION*CNT_W (12) | Packed per-region wait fields, field k at [3k+2:3k] |
| mode_i | input | 1 | 0 = N waits, 1 = 2N+1 waits |
| iosel_o | output | 1 | I/O select strobe, high for the whole access |
| ready_o | output | 1 | One-cycle access completion |
| io_wr_o | output | 1 | Captured direction for the current access |

## Verification
The assertions watch every cycle. They check that ready only appears inside a strobe and ends it, that the strobe never drops before ready, and that an idle request always opens an access. They also check that the direction stays frozen during an access and that the strobe length matches the wait length computed from the port values seen at acceptance. Only the bench's scenarios can show the fixed results across region, mode, count and direction combinations. These include the 0 and 15 wait extremes, ignored high address bits, and that reconfiguration and repeated requests during a busy access leave it untouched.

// File: rtl/io_wait_pkg.sv
package io_wait_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/io_region_sel.sv
module io_region_sel #(
  parameter int IO_AW   = 11,
  parameter int NREGION = 4,
  parameter int CNT_W   = 3
) (
  input  logic [IO_AW-1:0]         addr,
  input  logic [NREGION*CNT_W-1:0] cfg,
  output logic [CNT_W-1:0]         n_sel
);
  localparam int RB = (NREGION > 1) ? $clog2(NREGION) : 1;

  logic [CNT_W-1:0] field [NREGION];

  for (genvar g = 0; g < NREGION; g++) begin : g_unpack
    assign field[g] = cfg[g*CNT_W +: CNT_W];
  end

  if (NREGION > 1) begin : g_multi
    logic [RB-1:0] idx;
    logic [IO_AW-RB-1:0] unused_low;
    assign idx        = addr[IO_AW-1 -: RB];
    assign unused_low = addr[IO_AW-RB-1:0];
    assign n_sel      = field[idx];
  end else begin : g_single
    logic [IO_AW-1:0] unused_addr;
    assign unused_addr = addr;
    assign n_sel       = field[0];
  end
endmodule

// File: rtl/io_wait_calc.sv
module io_wait_calc #(
  parameter int CNT_W  = 3,
  localparam int WAIT_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0]  n,
  input  logic              stretch,
  output logic [WAIT_W-1:0] waits
);
  always_comb begin
    if (stretch) waits = {n, 1'b1};
    else         waits = {1'b0, n};
  end
endmodule

// File: rtl/io_access_seq.sv
module io_access_seq
  import io_wait_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [WAIT_W-1:0] waits,
  output logic              iosel,
  output logic              ready,
  output logic              wr_q
);
  seq_state_t        state;
  logic [WAIT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      remain <= '0;
      iosel  <= 1'b0;
      ready  <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            iosel  <= 1'b1;
            wr_q   <= wr;
            remain <= waits;
            if (waits == '0) begin
              state <= ST_DONE;
              ready <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          remain <= remain - 1'b1;
          if (remain == WAIT_W'(1)) begin
            state <= ST_DONE;
            ready <= 1'b1;
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
          ready <= 1'b0;
          iosel <= 1'b0;
          wr_q  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen #(
  parameter int BUS_AW  = 14,
  parameter int IO_AW   = 11,
  parameter int NREGION = 4,
  parameter int CNT_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_i,
  input  logic [BUS_AW-1:0]        addr_i,
  input  logic                     wr_i,
  input  logic [NREGION*CNT_W-1:0] wait_cfg_i,
  input  logic                     mode_i,
  output logic                     iosel_o,
  output logic                     ready_o,
  output logic                     io_wr_o
);
  localparam int WAIT_W = CNT_W + 1;

  logic [CNT_W-1:0]  n_sel;
  logic [WAIT_W-1:0] waits;

  if (BUS_AW > IO_AW) begin : g_hi
    logic [BUS_AW-IO_AW-1:0] unused_hi;
    assign unused_hi = addr_i[BUS_AW-1:IO_AW];
  end

  io_region_sel #(.IO_AW(IO_AW), .NREGION(NREGION), .CNT_W(CNT_W)) u_sel (
    .addr  (addr_i[IO_AW-1:0]),
    .cfg   (wait_cfg_i),
    .n_sel (n_sel)
  );

  io_wait_calc #(.CNT_W(CNT_W)) u_calc (
    .n       (n_sel),
    .stretch (mode_i),
    .waits   (waits)
  );

  io_access_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .req   (req_i),
    .wr    (wr_i),
    .waits (waits),
    .iosel (iosel_o),
    .ready (ready_o),
    .wr_q  (io_wr_o)
  );
endmodule

// File: rtl/io_wait_chk.sv
module io_wait_chk #(
  parameter int BUS_AW  = 14,
  parameter int IO_AW   = 11,
  parameter int NREGION = 4,
  parameter int CNT_W   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_i,
  input logic [BUS_AW-1:0]        addr_i,
  input logic                     wr_i,
  input logic [NREGION*CNT_W-1:0] wait_cfg_i,
  input logic                     mode_i,
  input logic                     iosel_o,
  input logic                     ready_o,
  input logic                     io_wr_o
);
  localparam int RB = (NREGION > 1) ? $clog2(NREGION) : 1;

  int exp_len;
  int cyc;

  function automatic int calc_len(input logic [BUS_AW-1:0] a,
                                  input logic [NREGION*CNT_W-1:0] c,
                                  input logic m);
    int k;
    int n;
    k = (NREGION > 1) ? int'(a[IO_AW-1 -: RB]) : 0;
    n = int'(c[k*CNT_W +: CNT_W]);
    return (m ? 2*n + 1 : n) + 1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_len <= 0;
      cyc     <= 0;
    end else if (!iosel_o && req_i) begin
      exp_len <= calc_len(addr_i, wait_cfg_i, mode_i);
      cyc     <= 1;
    end else if (iosel_o) begin
      cyc <= cyc + 1;
    end
  end

  // R7
  ready_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> iosel_o);
  // R7
  strobe_ends_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !iosel_o && !ready_o);
  // R7
  strobe_held_chk: assert property (@(posedge clk) disable iff (rst)
    iosel_o && !ready_o |=> iosel_o);
  // R8
  idle_accept_chk: assert property (@(posedge clk) disable iff (rst)
    !iosel_o && req_i |=> iosel_o);
  // R5
  dir_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    iosel_o && !ready_o |=> $stable(io_wr_o));
  // R3 R4 R6 R9
  wait_len_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> cyc == exp_len);
endmodule

bind io_wait_gen io_wait_chk #(
  .BUS_AW(BUS_AW), .IO_AW(IO_AW), .NREGION(NREGION), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .wr_i(wr_i),
  .wait_cfg_i(wait_cfg_i), .mode_i(mode_i), .iosel_o(iosel_o),
  .ready_o(ready_o), .io_wr_o(io_wr_o)
);

// File: tb/io_wait_gen_bench.sv
module io_wait_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [13:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic [11:0] wait_cfg_i = '0;
  logic        mode_i = 1'b0;
  logic        iosel_o, ready_o, io_wr_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  io_wait_gen u_io_wait_gen (
    .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .wr_i(wr_i),
    .wait_cfg_i(wait_cfg_i), .mode_i(mode_i), .iosel_o(iosel_o),
    .ready_o(ready_o), .io_wr_o(io_wr_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One access on region rg with field value n; perturb changes inputs while busy.
  task automatic run_access(input bit md, input int rg, input int n, input bit wr,
                            input bit perturb, input int hi);
    int exp_w;
    int len;
    bit held;
    logic [11:0] cfg;
    for (int k = 0; k < 4; k++) cfg[k*3 +: 3] = 3'((n + 3*k + 5) % 8);
    cfg[rg*3 +: 3] = 3'(n);
    exp_w = md ? 2*n + 1 : n;
    @(negedge clk);
    wait_cfg_i = cfg;
    mode_i     = md;
    wr_i       = wr;
    addr_i     = {3'(hi), 2'(rg), 9'((n * 37 + rg * 11) % 512)};
    req_i      = 1'b1;
    @(negedge clk);
    req_i = perturb;
    len  = 1;
    held = 1'b1;
    if (perturb) begin
      wait_cfg_i = ~cfg;
      mode_i     = ~md;
      wr_i       = ~wr;
      addr_i     = ~addr_i;
    end
    while (!ready_o && len < 20) begin
      if (!iosel_o || io_wr_o != wr) held = 1'b0;
      @(negedge clk);
      len++;
    end
    if (!iosel_o || io_wr_o != wr) held = 1'b0;
    req_i = 1'b0;
    if (md) check(len == exp_w + 1, "R4 2N+1 length", len, exp_w + 1);
    else    check(len == exp_w + 1, "R3 N length", len, exp_w + 1);
    if (exp_w == 0) check(len == 1, "R9 zero wait", len, 1);
    check(held, "R5 strobe/direction held", int'(held), 1);
    if (perturb) check(len == exp_w + 1, "R6 captured at start", len, exp_w + 1);
    @(negedge clk);
    check(!iosel_o && !ready_o, "R7 strobe low after ready", int'(iosel_o), 0);
    if (perturb) check(!iosel_o, "R8 busy request ignored", int'(iosel_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!iosel_o && !ready_o && !io_wr_o, "R1 reset state",
          int'({iosel_o, ready_o, io_wr_o}), 0);
    @(negedge clk);
    check(!iosel_o, "R7 idle strobe low", int'(iosel_o), 0);
    for (int md = 0; md < 2; md++)
      for (int rg = 0; rg < 4; rg++)
        for (int n = 0; n < 8; n++)
          for (int w = 0; w < 2; w++)
            run_access(md[0], rg, n, w[0], 1'b0, (n + rg + w) % 8);
    // R2: upper address bits swept, regions vary
    for (int hi = 0; hi < 8; hi++)
      run_access(hi[0], hi % 4, (hi * 3) % 8, hi[1], 1'b0, hi);
    // R6 R8: reconfigure and hold request while busy
    for (int rg = 0; rg < 4; rg++)
      for (int n = 0; n < 8; n += 3)
        run_access(rg[0], rg, n, rg[1], 1'b1, rg);
    run_access(1'b1, 3, 7, 1'b1, 1'b1, 7);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule